// File: doc/BRIEF.md
# Re-Reference Interval Replacement Engine for One Cache Set

This block keeps the replacement state of a single set in a set-associative cache. Each way holds a small saturating counter that estimates how long it will be before that way is used again: zero means soon, the all-ones value means far off. The cache controller reports hits with a way index and, when a line must be brought in, raises a fill request. The engine then finds a victim by looking for a way whose counter is at the top value. If none is there, it ages every way by one step per cycle until one reaches the top. It returns that way's index and loads the new line's counter with the value one below the top. A newly filled line therefore starts close to eviction but not at it, so a one-time stream of fills cannot push out lines that have already seen hits.

A mode input selects how a hit is credited. In hit-priority mode the counter drops straight to zero. In frequency-priority mode it drops by one and stops at zero. With a counter width of one bit, the block behaves as the familiar not-recently-used scheme. The engine is busy from the moment it accepts a fill until the cycle in which it reports the victim. While it is busy it takes no new hit or fill.

Top module: `rrip_set_engine`

## Requirements
- R1: After reset every way's counter is at the top value 2^PW-1, `ready` is 1 and `victim_valid` is 0, so consecutive fills with no hits return ways 0, 1, 2, ... in order.
- R2: The victim is the lowest-numbered way whose counter equals 2^PW-1.
- R3: If no way holds 2^PW-1, all counters rise by one each cycle and saturate at 2^PW-1. `victim_valid` rises exactly 1 + (2^PW-1 - largest counter) clock edges after the edge that accepted the fill.
- R4: The victim way's counter is loaded with 2^PW-2 in the cycle the victim is reported.
- R5: With `freq_mode`=0 (hit-priority), an accepted hit sets that way's counter to 0.
- R6: With `freq_mode`=1 (frequency-priority), an accepted hit lowers that way's counter by one, saturating at 0.
- R7: `fill_req` and `hit_valid` are taken only while `ready` is 1. `ready` falls after an accepted fill and returns with the victim report. Requests presented while `ready` is 0 change no counter.
- R8: A hit and a fill accepted in the same cycle are ordered with the hit first, so the fill's victim search sees the hit's update.
- R9: With PW=1 the block is a not-recently-used policy: fills and hits both write 0, and the victim is the first way holding 1.
- R10: `victim_valid` is a single-cycle pulse, and `victim_way` is valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_mode | input | 1 | Hit credit: 0 sets the counter to zero, 1 decrements it |
| hit_valid | input | 1 | A hit on `hit_way`, taken when `ready` is 1 |
| hit_way | input | $clog2(WAYS) | Way index of the hit |
| fill_req | input | 1 | Request for a victim way, taken when `ready` is 1 |
| ready | output | 1 | Engine idle and able to take a hit or a fill |
| victim_valid | output | 1 | One-cycle pulse that reports the chosen victim |
| victim_way | output | $clog2(WAYS) | Index of the chosen victim way |

## Verification
The bench steers the set into states where the search has to age several times, and it checks the exact cycle in which the victim appears. A design that aged once too often, or that reported the victim a cycle late, would miss that cycle. Ties at the top value are checked to resolve toward way 0. An engine that scanned from the high end would pick the wrong way right after reset. Hits in both credit modes are followed by fills, so that a decrement turned into a clear, or an unsaturated decrement that wrapped to the top, would show up as a changed eviction order. The bench also pokes fills and hits while the engine is busy, issues a simultaneous hit and fill on the way that would otherwise be evicted, and runs a one-bit instance whose aging must wrap every way back to the top in a single step.

// File: rtl/rrip_pkg.sv
package rrip_pkg;

  typedef enum logic {
    SEQ_IDLE   = 1'b0,
    SEQ_SEARCH = 1'b1
  } seq_state_e;

  // Saturating increment of a counter held in the low bits, bounded by top.
  function automatic logic [7:0] rrpv_sat_inc(input logic [7:0] v, input logic [7:0] top);
    logic [7:0] r;
    if (v >= top) r = top;
    else          r = v + 8'd1;
    return r;
  endfunction

  // Counter value after a hit: cleared, or decremented with a floor at zero.
  function automatic logic [7:0] rrpv_on_hit(input logic [7:0] v, input logic freq);
    logic [7:0] r;
    if (!freq)          r = 8'd0;
    else if (v == 8'd0) r = 8'd0;
    else                r = v - 8'd1;
    return r;
  endfunction

endpackage

// File: rtl/rrip_way_cell.sv
module rrip_way_cell #(
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_en,
  input  logic          hit_en,
  input  logic          freq_mode,
  input  logic          age_en,
  output logic [PW-1:0] val
);
  localparam logic [PW-1:0] TOPV = {PW{1'b1}};
  localparam logic [PW-1:0] INSV = PW'((2 ** PW) - 2);

  logic [PW-1:0] age_next;
  logic [PW-1:0] hit_next;

  always_comb begin
    age_next = PW'(rrip_pkg::rrpv_sat_inc(8'(val), 8'(TOPV)));
    hit_next = PW'(rrip_pkg::rrpv_on_hit(8'(val), freq_mode));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val <= TOPV;
    else if (ins_en) val <= INSV;
    else if (hit_en) val <= hit_next;
    else if (age_en) val <= age_next;
  end

  // R3
  age_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_en && !ins_en && !hit_en && val != TOPV) |=> (val == $past(val) + 1'b1));

  // R3
  age_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_en && !ins_en && !hit_en && val == TOPV) |=> (val == TOPV));

  // R5
  hit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_en && !ins_en && !freq_mode) |=> (val == '0));

  // R6
  hit_decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_en && !ins_en && freq_mode && val != '0) |=> (val == $past(val) - 1'b1));

  // R6
  hit_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_en && !ins_en && freq_mode && val == '0) |=> (val == '0));

endmodule

// File: rtl/rrip_victim_pick.sv
module rrip_victim_pick #(
  parameter int WAYS = 16,
  parameter int PW   = 2,
  localparam int WIDX = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][PW-1:0] vals,
  output logic                    found,
  output logic [WIDX-1:0]         idx
);
  localparam logic [PW-1:0] TOPV = {PW{1'b1}};

  logic [WAYS-1:0] at_top;

  for (genvar g = 0; g < WAYS; g++) begin : g_match
    assign at_top[g] = (vals[g] == TOPV);
  end

  // Walk from the highest way down so the lowest match is the last one written.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (at_top[i]) begin
        found = 1'b1;
        idx   = WIDX'(i);
      end
    end
  end

endmodule

// File: rtl/rrip_seq.sv
module rrip_seq #(
  parameter int WAYS = 16,
  localparam int WIDX = $clog2(WAYS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fill_req,
  input  logic            hit_valid,
  input  logic            found,
  input  logic [WIDX-1:0] pick_idx,
  output logic            ready,
  output logic            fill_accept,
  output logic            hit_accept,
  output logic            age_step,
  output logic            insert_fire,
  output logic            victim_valid,
  output logic [WIDX-1:0] victim_way
);
  import rrip_pkg::*;

  seq_state_e state;

  assign ready       = (state == SEQ_IDLE);
  assign fill_accept = ready && fill_req;
  assign hit_accept  = ready && hit_valid;
  assign insert_fire = (state == SEQ_SEARCH) && found;
  assign age_step    = (state == SEQ_SEARCH) && !found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= SEQ_IDLE;
      victim_valid <= 1'b0;
      victim_way   <= '0;
    end else begin
      victim_valid <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (fill_req) state <= SEQ_SEARCH;
        end
        SEQ_SEARCH: begin
          if (found) begin
            victim_valid <= 1'b1;
            victim_way   <= pick_idx;
            state        <= SEQ_IDLE;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R7
  busy_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_accept |=> !ready);

  // R10
  victim_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |=> !victim_valid);

  // R3
  aging_defers_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    age_step |=> (!victim_valid && !ready));

  // R10
  victim_from_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> ($past(insert_fire) && ready));

endmodule

// File: rtl/rrip_set_engine.sv
module rrip_set_engine #(
  parameter int WAYS = 16,
  parameter int PW   = 2,
  localparam int WIDX = $clog2(WAYS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            freq_mode,
  input  logic            hit_valid,
  input  logic [WIDX-1:0] hit_way,
  input  logic            fill_req,
  output logic            ready,
  output logic            victim_valid,
  output logic [WIDX-1:0] victim_way
);
  localparam logic [PW-1:0] INSV = PW'((2 ** PW) - 2);

  logic [WAYS-1:0][PW-1:0] way_val;
  logic                    found;
  logic [WIDX-1:0]         pick_idx;
  logic                    fill_accept;
  logic                    hit_accept;
  logic                    age_step;
  logic                    insert_fire;

  rrip_seq #(.WAYS(WAYS)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .fill_req     (fill_req),
    .hit_valid    (hit_valid),
    .found        (found),
    .pick_idx     (pick_idx),
    .ready        (ready),
    .fill_accept  (fill_accept),
    .hit_accept   (hit_accept),
    .age_step     (age_step),
    .insert_fire  (insert_fire),
    .victim_valid (victim_valid),
    .victim_way   (victim_way)
  );

  rrip_victim_pick #(.WAYS(WAYS), .PW(PW)) u_pick (
    .vals  (way_val),
    .found (found),
    .idx   (pick_idx)
  );

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic ins_here;
    logic hit_here;
    assign ins_here = insert_fire && (pick_idx == WIDX'(g));
    assign hit_here = hit_accept && (hit_way == WIDX'(g));

    rrip_way_cell #(.PW(PW)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .ins_en    (ins_here),
      .hit_en    (hit_here),
      .freq_mode (freq_mode),
      .age_en    (age_step),
      .val       (way_val[g])
    );
  end

  // R4
  insert_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> (way_val[victim_way] == INSV));

  // R7
  idle_no_aging_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!age_step && !insert_fire));

  // R8
  hit_then_search_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_accept && fill_accept) |=> !ready);

endmodule

// File: tb/test_rrip_set_engine.sv
module test_rrip_set_engine;

  localparam int WAYS = 16;
  localparam int WIDX = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            freq_mode [2];
  logic            hit_valid [2];
  logic [WIDX-1:0] hit_way   [2];
  logic            fill_req  [2];
  logic            ready     [2];
  logic            vvalid    [2];
  logic [WIDX-1:0] vway      [2];

  int applied = 0;
  int miscompares = 0;
  int mdl [2][WAYS];
  int topv [2] = '{3, 1};

  rrip_set_engine #(.WAYS(WAYS), .PW(2)) i_rrip_set_engine (
    .clk(clk), .rst_n(rst_n), .freq_mode(freq_mode[0]), .hit_valid(hit_valid[0]),
    .hit_way(hit_way[0]), .fill_req(fill_req[0]), .ready(ready[0]),
    .victim_valid(vvalid[0]), .victim_way(vway[0]));

  rrip_set_engine #(.WAYS(WAYS), .PW(1)) i_rrip_set_engine_nru (
    .clk(clk), .rst_n(rst_n), .freq_mode(freq_mode[1]), .hit_valid(hit_valid[1]),
    .hit_way(hit_way[1]), .fill_req(fill_req[1]), .ready(ready[1]),
    .victim_valid(vvalid[1]), .victim_way(vway[1]));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    applied++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Model of one fill, written from the requirements: age until a top value exists,
  // take the lowest such way, load it with top-1.
  function automatic int model_fill(input int u, output int ages);
    int w;
    ages = 0;
    w = -1;
    while (w < 0) begin
      for (int i = WAYS - 1; i >= 0; i--) if (mdl[u][i] == topv[u]) w = i;
      if (w < 0) begin
        for (int i = 0; i < WAYS; i++) if (mdl[u][i] < topv[u]) mdl[u][i]++;
        ages++;
      end
    end
    mdl[u][w] = topv[u] - 1;
    return w;
  endfunction

  function automatic void model_hit(input int u, input int w, input bit fm);
    if (!fm) mdl[u][w] = 0;
    else if (mdl[u][w] > 0) mdl[u][w]--;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int u = 0; u < 2; u++) begin
      freq_mode[u] = 1'b0; hit_valid[u] = 1'b0; hit_way[u] = '0; fill_req[u] = 1'b0;
      for (int i = 0; i < WAYS; i++) mdl[u][i] = topv[u];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int u = 0; u < 2; u++) begin
      check(ready[u] == 1'b1, "R1 ready after reset", int'(ready[u]), 1);
      check(vvalid[u] == 1'b0, "R1 no victim after reset", int'(vvalid[u]), 0);
    end
  endtask

  task automatic do_hit(input int u, input int w, input bit fm);
    check(ready[u] == 1'b1, "R7 ready before hit", int'(ready[u]), 1);
    freq_mode[u] = fm; hit_valid[u] = 1'b1; hit_way[u] = WIDX'(w);
    @(posedge clk);
    @(negedge clk);
    hit_valid[u] = 1'b0;
    model_hit(u, w, fm);
  endtask

  // hw >= 0 issues a hit on that way in the same cycle as the fill (R8).
  // poke drives fill_req and hit_valid while the engine is busy (R7).
  task automatic do_fill(input int u, input bit poke, input int hw, input bit fm, input string req);
    int ages;
    int exp_w;
    check(ready[u] == 1'b1, "R7 ready before fill", int'(ready[u]), 1);
    fill_req[u] = 1'b1;
    if (hw >= 0) begin
      freq_mode[u] = fm; hit_valid[u] = 1'b1; hit_way[u] = WIDX'(hw);
      model_hit(u, hw, fm);
    end
    exp_w = model_fill(u, ages);
    @(posedge clk);
    @(negedge clk);
    fill_req[u] = 1'b0;
    hit_valid[u] = 1'b0;
    check(ready[u] == 1'b0, "R7 busy after fill accept", int'(ready[u]), 0);
    if (poke) begin
      fill_req[u] = 1'b1; hit_valid[u] = 1'b1; hit_way[u] = WIDX'(exp_w); freq_mode[u] = 1'b0;
    end
    for (int k = 0; k <= ages; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k < ages) begin
        check(vvalid[u] == 1'b0, "R3 no victim while aging", int'(vvalid[u]), 0);
        check(ready[u] == 1'b0, "R7 busy while aging", int'(ready[u]), 0);
      end else begin
        check(vvalid[u] == 1'b1, "R3 victim on expected cycle", int'(vvalid[u]), 1);
        check(int'(vway[u]) == exp_w, req, int'(vway[u]), exp_w);
        check(ready[u] == 1'b1, "R7 ready with victim", int'(ready[u]), 1);
      end
    end
    fill_req[u] = 1'b0; hit_valid[u] = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(vvalid[u] == 1'b0, "R10 single-cycle victim pulse", int'(vvalid[u]), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  task automatic t_reset_order();
    do_reset();
    for (int i = 0; i < WAYS; i++) do_fill(0, 1'b0, -1, 1'b0, "R1 reset fill order");
  endtask

  task automatic t_aging_and_insert();
    // all ways at 2 now: next fill ages once and takes way 0 (R3, R4)
    do_fill(0, 1'b0, -1, 1'b0, "R3 aged victim way");
    do_fill(0, 1'b0, -1, 1'b0, "R2 lowest top way");
    do_fill(0, 1'b0, -1, 1'b0, "R4 fill value observed via order");
  endtask

  task automatic t_hit_modes();
    do_reset();
    for (int i = 0; i < WAYS; i++) do_fill(0, 1'b0, -1, 1'b0, "R1 refill");
    do_hit(0, 0, 1'b0);
    do_hit(0, 3, 1'b1);
    do_hit(0, 7, 1'b1);
    do_hit(0, 7, 1'b1);
    do_hit(0, 7, 1'b1);
    do_hit(0, 9, 1'b0);
    do_hit(0, 9, 1'b1);
    for (int i = 0; i < 20; i++) do_fill(0, 1'b0, -1, 1'b0, "R5 R6 hit credit order");
  endtask

  task automatic t_busy_ignore();
    do_hit(0, 2, 1'b0);
    do_hit(0, 4, 1'b0);
    for (int i = 0; i < 6; i++) do_fill(0, 1'b1, -1, 1'b0, "R7 busy pokes ignored");
    for (int i = 0; i < 6; i++) do_fill(0, 1'b0, -1, 1'b0, "R7 order after pokes");
  endtask

  task automatic t_same_cycle();
    do_reset();
    do_fill(0, 1'b0, 0, 1'b0, "R8 hit before fill");
    do_fill(0, 1'b0, 2, 1'b1, "R8 freq hit before fill");
    do_fill(0, 1'b0, -1, 1'b0, "R8 following fill");
  endtask

  task automatic t_nru();
    do_reset();
    for (int i = 0; i < WAYS; i++) do_fill(1, 1'b0, -1, 1'b0, "R9 nru first fills");
    do_fill(1, 1'b0, -1, 1'b0, "R9 nru wrap victim");
    do_hit(1, 1, 1'b0);
    do_hit(1, 2, 1'b1);
    for (int i = 0; i < 5; i++) do_fill(1, 1'b0, -1, 1'b0, "R9 nru after hits");
  endtask

  initial begin
    for (int u = 0; u < 2; u++) begin
      freq_mode[u] = 1'b0; hit_valid[u] = 1'b0; hit_way[u] = '0; fill_req[u] = 1'b0;
    end
    t_reset_order();
    t_aging_and_insert();
    t_hit_modes();
    t_busy_ignore();
    t_same_cycle();
    t_nru();
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule